// File: doc/BRIEF.md
# Bidirectional Up/Down Timer

A 16-bit counter that advances by one step per qualifying event, in either direction, from one of four event sources picked by a mode field: a power-of-two prescaled internal clock, both edges of an external clock pin, a two-phase quadrature encoder on the two external pins, or the wrap pulses of a companion timer. In the internal and external clock modes the step direction comes either from a control bit or from the external direction pin.

Software-style access is a single write port: one select bit picks the control register or the count register. The count is always visible on `count_o`. A wrap upward past the top value and a wrap downward past zero each set a sticky flag. Any write clears both flags. Single-cycle wrap pulses are also brought out, so that a second instance in cascade mode can count this timer's wraps.

Top module: `bidir_timer`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0, both flags are 0, both wrap pulses are 0 and the control register is 0 (counting disabled).
- R2: A write with `wr_sel_i`=1 loads `wr_data_i` into the count, visible the cycle after the write edge; no step is applied at that edge.
- R3: A write with `wr_sel_i`=0 loads the control register from `wr_data_i[7:0]`: bit 7 enable, bits 6:4 prescale exponent p, bit 3 direction bit (1 = up), bit 2 direction source (1 = pin), bits 1:0 mode (0 internal, 1 external clock, 2 quadrature, 3 cascade). In mode 0 the prescaler restarts at that write, and k clock edges later the count has moved by floor(k / 2^p).
- R4: In modes 0 and 1, with bit 2 set the count rises while `tdir_i` is high and falls while it is low; with bit 2 clear `tdir_i` is ignored and bit 3 sets the direction.
- R5: In mode 1 each rising and each falling edge of `tclk_i` moves the count by one; the new value appears on the third clock edge after the input change.
- R6: In mode 2 the pair {`tclk_i`,`tdir_i`} is a quadrature pair; 00→10→11→01→00 counts up one per transition and the reverse order counts down.
- R7: In mode 2 a change of both phases between two samples leaves the count unchanged, and decoding resumes from the new pair.
- R8: In mode 3 a cycle with `casc_up_i` alone adds one, `casc_dn_i` alone subtracts one, and both together do nothing.
- R9: A step up from 0xFFFF gives 0, pulses `wrap_up_o` in the cycle before, and sets `ovf_o`.
- R10: A step down from 0 gives 0xFFFF, pulses `wrap_dn_o` in the cycle before, and sets `unf_o`.
- R11: Any write clears both flags, except that a wrap at the same edge sets its flag.
- R12: With enable clear no source moves the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | 0 = control register, 1 = count register |
| wr_data_i | input | 16 | Write data |
| tclk_i | input | 1 | External clock, or quadrature phase A |
| tdir_i | input | 1 | External direction, or quadrature phase B |
| casc_up_i | input | 1 | Companion timer wrapped upward (one cycle) |
| casc_dn_i | input | 1 | Companion timer wrapped downward (one cycle) |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | Sticky upward-wrap flag |
| unf_o | output | 1 | Sticky downward-wrap flag |
| wrap_up_o | output | 1 | Step up from 0xFFFF happens at the next edge |
| wrap_dn_o | output | 1 | Step down from 0 happens at the next edge |

## Verification
Every internal fault shows up on `count_o`. A wrong prescaler phase shifts the count by one within 2^p cycles. A broken synchronizer or edge detector gives a missing, doubled or late step three edges after a pin change. A wrong entry in the quadrature table gives a count that moves the wrong way, or does not move, on the one transition that uses that entry. Flag faults show on `ovf_o`/`unf_o` at the wrap edge or at the next write. The bench therefore samples the count after every single event, and it checks the flags right at wraps and right after writes.

// File: rtl/bidir_timer_pkg.sv
`timescale 1ns/1ps
package bidir_timer_pkg;
  localparam int PRE_W = 3;

  typedef enum logic [1:0] {
    MODE_INT  = 2'd0,
    MODE_EXT  = 2'd1,
    MODE_QUAD = 2'd2,
    MODE_CASC = 2'd3
  } cnt_mode_e;

  typedef struct packed {
    logic             enable;
    logic [PRE_W-1:0] pre_sel;
    logic             dir_up;
    logic             dir_pin;
    cnt_mode_e        mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_in_sync.sv
`timescale 1ns/1ps
module tmr_in_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], in_i[i]};
    end
    assign lvl_o[i] = sh_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= lvl_o;
  end
endmodule

// File: rtl/tmr_quad_dec.sv
`timescale 1ns/1ps
module tmr_quad_dec (
  input  logic [1:0] prev_i,  // {a,b}
  input  logic [1:0] cur_i,   // {a,b}
  output logic       up_o,
  output logic       dn_o
);
  always_comb begin
    up_o = 1'b0;
    dn_o = 1'b0;
    case ({prev_i, cur_i})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: up_o = 1'b1;
      4'b0001, 4'b0111, 4'b1110, 4'b1000: dn_o = 1'b1;
      default: ; // no change or double jump
    endcase
  end
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [PRE_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;

  assign mask   = ~({DIV_W{1'b1}} << sel_i);
  assign tick_o = en_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bidir_timer.sv
`timescale 1ns/1ps
module bidir_timer
  import bidir_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             tclk_i,
  input  logic             tdir_i,
  input  logic             casc_up_i,
  input  logic             casc_dn_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             wrap_up_o,
  output logic             wrap_dn_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] count_q;
  logic             ovf_q, unf_q;
  logic [1:0]       pin_lvl, pin_prev;
  logic             pre_tick, q_up, q_dn;
  logic             adv, dir_lvl, step_up, step_dn;
  logic             ctrl_wr, cnt_wr;

  assign ctrl_wr = wr_en_i && !wr_sel_i;
  assign cnt_wr  = wr_en_i &&  wr_sel_i;

  // bit 0: tclk / phase A, bit 1: tdir / phase B
  tmr_in_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   ({tdir_i, tclk_i}),
    .lvl_o  (pin_lvl),
    .prev_o (pin_prev)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_wr),
    .en_i   (ctrl_q.enable),
    .sel_i  (ctrl_q.pre_sel),
    .tick_o (pre_tick)
  );

  tmr_quad_dec u_quad (
    .prev_i ({pin_prev[0], pin_prev[1]}),
    .cur_i  ({pin_lvl[0],  pin_lvl[1]}),
    .up_o   (q_up),
    .dn_o   (q_dn)
  );

  assign dir_lvl = ctrl_q.dir_pin ? pin_lvl[1] : ctrl_q.dir_up;

  always_comb begin
    adv     = 1'b0;
    step_up = 1'b0;
    step_dn = 1'b0;
    unique case (ctrl_q.mode)
      MODE_INT, MODE_EXT: begin
        adv     = (ctrl_q.mode == MODE_INT) ? pre_tick : (pin_lvl[0] ^ pin_prev[0]);
        step_up = adv &&  dir_lvl;
        step_dn = adv && !dir_lvl;
      end
      MODE_QUAD: begin
        step_up = q_up;
        step_dn = q_dn;
      end
      MODE_CASC: begin
        step_up = casc_up_i && !casc_dn_i;
        step_dn = casc_dn_i && !casc_up_i;
      end
      default: ;
    endcase
    if (!ctrl_q.enable || cnt_wr) begin
      step_up = 1'b0;
      step_dn = 1'b0;
    end
  end

  assign wrap_up_o = step_up && (count_q == {CNT_W{1'b1}});
  assign wrap_dn_o = step_dn && (count_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      count_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (cnt_wr)       count_q <= wr_data_i;
      else if (step_up) count_q <= count_q + 1'b1;
      else if (step_dn) count_q <= count_q - 1'b1;
      // wrap at the same edge wins over the clear
      ovf_q <= wrap_up_o || (ovf_q && !wr_en_i);
      unf_q <= wrap_dn_o || (unf_q && !wr_en_i);
    end
  end

  assign count_o = count_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;
endmodule

// File: rtl/bidir_timer_chk.sv
`timescale 1ns/1ps
module bidir_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic             en_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o,
  input logic             unf_o,
  input logic             wrap_up_o,
  input logic             wrap_dn_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset: assert (count_o == '0 && !ovf_o && !unf_o && !wrap_up_o && !wrap_dn_o);
    end
  end

  a_r2_count_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> (count_o == $past(wr_data_i)));

  a_r12_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_en_i) |=> $stable(count_o));

  // R6: no source moves the count by more than one per cycle
  a_r6_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (count_o == $past(count_o) ||
                  count_o == $past(count_o) + CNT_W'(1) ||
                  count_o == $past(count_o) - CNT_W'(1)));

  a_r9_wrap_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_up_o |=> (count_o == '0 && ovf_o));

  a_r10_wrap_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_dn_o |=> (count_o == {CNT_W{1'b1}} && unf_o));

  a_r11_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wrap_up_o && !wrap_dn_o) |=> (!ovf_o && !unf_o));
endmodule

bind bidir_timer bidir_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .en_i      (ctrl_q.enable),
  .count_o   (count_o),
  .ovf_o     (ovf_o),
  .unf_o     (unf_o),
  .wrap_up_o (wrap_up_o),
  .wrap_dn_o (wrap_dn_o)
);

// File: tb/bidir_timer_test.sv
`timescale 1ns/1ps
module bidir_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tclk = 1'b0, tdir = 1'b0, c_up = 1'b0, c_dn = 1'b0;
  logic [15:0] count;
  logic        ovf, unf, w_up, w_dn;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bidir_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .tclk_i(tclk), .tdir_i(tdir), .casc_up_i(c_up), .casc_dn_i(c_dn),
    .count_o(count), .ovf_o(ovf), .unf_o(unf), .wrap_up_o(w_up), .wrap_dn_o(w_dn)
  );

  function automatic logic [15:0] mk_ctrl(input bit en, input int p, input bit up,
                                          input bit pin, input int mode);
    return {8'h00, en, 3'(p), up, pin, 2'(mode)};
  endfunction

  function automatic logic [15:0] exp_int(input logic [15:0] v, input int k, input int p,
                                          input bit up);
    int n = k >> p;
    return up ? v + 16'(n) : v - 16'(n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic wr(input bit sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tog_clk();
    tclk = ~tclk;
    wait_n(4);
  endtask

  task automatic set_ab(input bit a, input bit b);
    tclk = a; tdir = b;
    wait_n(4);
  endtask

  task automatic pulse(input bit u, input bit d);
    c_up = u; c_dn = d;
    @(negedge clk);
    c_up = 1'b0; c_dn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    wait_n(3);
    chk("R1 reset", {count, ovf, unf, w_up, w_dn}, {16'h0, 4'b0});
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 disabled after reset", count, 16'h0);

    // R2: count write wins over a step at the same edge
    wr(1, 16'h0100);
    wr(0, mk_ctrl(1, 0, 1, 0, 0));
    chk("R3 p0 first edge pending", count, 16'h0100);
    wait_n(2);
    chk("R3 p0 two edges", count, 16'h0102);
    wr(1, 16'h1234);
    chk("R2 load suppresses step", count, 16'h1234);
    wait_n(1);
    chk("R2 resumes after load", count, 16'h1235);
    wr(0, 16'h0000);

    // R3 random prescaler/direction runs, R9/R10 flags near the edges
    for (int it = 0; it < 24; it++) begin
      int  p = $urandom_range(0, 3);
      int  k = $urandom_range(1, 48);
      bit  up = 1'($urandom_range(0, 1));
      int  n;
      v = (it % 3 == 0) ? (up ? 16'hFFF8 + 16'($urandom_range(0, 7)) : 16'($urandom_range(0, 7)))
                        : 16'($urandom);
      n = k >> p;
      wr(1, v);
      wr(0, mk_ctrl(1, p, up, 0, 0));
      wait_n(k);
      chk("R3 prescaled count", count, exp_int(v, k, p, up));
      chk("R9 ovf after run", ovf, (up && 32'(v) + 32'(n) > 32'hFFFF));
      chk("R10 unf after run", unf, (!up && 32'(v) < 32'(n)));
      wr(0, 16'h0000);
    end

    // R9 + R11: wrap at the same edge as a write keeps the flag
    wr(1, 16'hFFFE);
    wr(0, mk_ctrl(1, 0, 1, 0, 0));
    wait_n(1);
    chk("R9 at top", count, 16'hFFFF);
    chk("R9 wrap_up pulse", w_up, 1'b1);
    wr(0, mk_ctrl(1, 0, 1, 0, 0));
    chk("R9 wrapped to zero", count, 16'h0000);
    chk("R11 set wins over clear", ovf, 1'b1);
    wr(0, 16'h0000);
    chk("R11 write clears ovf", {ovf, count}, {1'b0, 16'h0001});

    // R10 underflow
    wr(1, 16'h0001);
    wr(0, mk_ctrl(1, 0, 0, 0, 0));
    wait_n(2);
    chk("R10 wrapped to top", {count, unf, ovf}, {16'hFFFF, 2'b10});
    wr(0, 16'h0000);
    chk("R11 write clears unf", unf, 1'b0);

    // R5 external clock, both edges, control-bit direction; R4 pin ignored
    tdir = 1'b0;
    wr(1, 16'd100);
    wr(0, mk_ctrl(1, 0, 1, 0, 1));
    wait_n(2);
    tclk = 1'b1;
    wait_n(2);
    chk("R5 latency not yet", count, 16'd100);
    wait_n(1);
    chk("R5 rising edge at third edge", count, 16'd101);
    wait_n(1);
    tog_clk();
    chk("R5 falling edge", count, 16'd102);
    tog_clk();
    chk("R4 pin ignored with bit2 clear", count, 16'd103);

    // R4 pin direction
    wr(0, mk_ctrl(1, 0, 1, 1, 1));
    for (int i = 0; i < 3; i++) tog_clk();
    chk("R4 pin low counts down", count, 16'd100);
    tdir = 1'b1;
    wait_n(4);
    for (int i = 0; i < 2; i++) tog_clk();
    chk("R4 pin high counts up", count, 16'd102);

    // R12 disabled
    wr(0, mk_ctrl(0, 0, 1, 1, 1));
    tog_clk();
    tog_clk();
    chk("R12 disabled ignores edges", count, 16'd102);
    pulse(1, 0);
    chk("R12 disabled ignores cascade", count, 16'd102);

    // R6/R7 quadrature
    set_ab(0, 0);
    wr(1, 16'd500);
    wr(0, mk_ctrl(1, 0, 0, 0, 2));
    set_ab(1, 0); chk("R6 00->10 up", count, 16'd501);
    set_ab(1, 1); chk("R6 10->11 up", count, 16'd502);
    set_ab(0, 1); chk("R6 11->01 up", count, 16'd503);
    set_ab(0, 0); chk("R6 01->00 up", count, 16'd504);
    set_ab(0, 1); chk("R6 00->01 down", count, 16'd503);
    set_ab(1, 1); chk("R6 01->11 down", count, 16'd502);
    set_ab(1, 0); chk("R6 11->10 down", count, 16'd501);
    set_ab(0, 0); chk("R6 10->00 down", count, 16'd500);
    set_ab(1, 1); chk("R7 double jump ignored", count, 16'd500);
    set_ab(0, 1); chk("R7 resumes from new pair", count, 16'd501);
    set_ab(0, 0); chk("R7 resumes next step", count, 16'd502);

    // R8 cascade
    wr(1, 16'h0000);
    wr(0, mk_ctrl(1, 0, 0, 0, 3));
    for (int i = 0; i < 5; i++) pulse(1, 0);
    chk("R8 up pulses", count, 16'd5);
    for (int i = 0; i < 2; i++) pulse(0, 1);
    chk("R8 down pulses", count, 16'd3);
    pulse(1, 1);
    chk("R8 both pulses cancel", count, 16'd3);
    wr(1, 16'h0000);
    pulse(0, 1);
    chk("R10 cascade underflow", {count, unf}, {16'hFFFF, 1'b1});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule